// File: doc/BRIEF.md
# Hardware Trap Priority Vectoring Unit

This block gathers the run-time exception conditions of a small CPU core and decides which one the core services next. Three fixed hardware classes exist: a reset group (hardware reset, software reset request, watchdog overflow), a system class (non-maskable interrupt, stack overflow, stack underflow) and a fault class (five instruction and bus fault conditions that share one entry point). Software trap requests carry a 7-bit number and are dispatched without a class change.

Every hardware condition is recorded in a sticky flag register that software clears by writing zeros. A small nesting stack remembers the trap level in service. A pending hardware trap is taken only when its class is strictly above the active level. A return pulse restores the level that was active before. While any hardware trap level is active, the unit asserts a block signal so that the interrupt controller holds off standard and peripheral-event requests. Each taken trap produces a one-cycle strobe with its trap number, its class and a vector address equal to four times the number.

Top module: `trap_vector_unit`

## Requirements
- R1: Flag bits are laid out as bit 0 non-maskable interrupt, bit 1 stack overflow, bit 2 stack underflow, bits 7:3 fault conditions 0..4. An event sets its bit on the next clock edge. Several faults in one cycle each set their own bit. A bit stays set until a write with a 0 in that position clears it. Writing a 1 has no effect. An event in the same cycle as a clearing write leaves the bit set.
- R2: Release of hardware reset, or a pulse on the software reset or watchdog input, clears every flag, every pending request and the nesting stack. One edge later the unit takes trap number 0x00 at vector 0 with class code 3, and the block output reads 0.
- R3: The system class uses class code 2. The non-maskable interrupt is taken as number 0x02 (vector 0x08), stack overflow as 0x04 (vector 0x10) and stack underflow as 0x06 (vector 0x18).
- R4: Any fault condition is taken as number 0x0A at vector 0x28 with class code 1. Faults pending together are serviced by a single take.
- R5: Among requests that can be taken, the higher class wins. Within the system class the lower number wins. A hardware trap taken in a cycle delays a pending software trap to a later cycle.
- R6: A hardware trap is taken only if its class is strictly above the active level, and that class then becomes the active level. A trap of equal or lower class stays pending.
- R7: A return pulse restores the level that was active before the last hardware take. With an empty stack the level stays 0. A pending trap that becomes eligible after a return is taken on the following edge.
- R8: A software trap with number n (0x00..0x7F) is taken at vector 4*n with class code 0, whatever the active level, and it leaves the active level unchanged.
- R9: The block output is 1 exactly while the active hardware level is nonzero.
- R10: A request sampled at edge k is taken at edge k+1. The take strobe is high for one cycle per taken trap. A hardware take never carries a number other than 0x00, 0x02, 0x04, 0x06 or 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| swRstReq | input | 1 | Software reset request pulse |
| wdtOvfReq | input | 1 | Watchdog overflow pulse |
| nmiReq | input | 1 | Non-maskable interrupt pulse |
| stkOvfReq | input | 1 | Stack overflow pulse |
| stkUnfReq | input | 1 | Stack underflow pulse |
| faultReq | input | FAULT_N | Fault condition pulses: undefined opcode, protected instruction, illegal word operand, illegal instruction access, illegal bus access |
| swTrapReq | input | 1 | Software trap request pulse |
| swTrapNum | input | 7 | Software trap number |
| trapRet | input | 1 | Return-from-hardware-trap pulse |
| flagWe | input | 1 | Flag register write enable |
| flagWdata | input | FAULT_N+3 | Flag write data, 0 clears a bit |
| flagRd | output | FAULT_N+3 | Flag register contents |
| takeTrap | output | 1 | One-cycle take strobe |
| trapVector | output | ADDR_W | Vector address of the taken trap |
| trapNum | output | 7 | Number of the taken trap |
| trapClass | output | 2 | Class of the taken trap, 0 for software |
| intBlock | output | 1 | Blocks standard and peripheral-event interrupts |

## Verification
The bench nests a system trap over a fault trap and stacks further system and fault requests behind them. A design that preempts on an equal class, or forgets the outer level on return, takes traps in the wrong order or drops the block output too early. It fires a software trap together with a hardware trap, and again under an active level. A design that lets software win or pushes a level for it shows a wrong class or a block output that changes. It also writes a clear in the same cycle as a new event, and fires a watchdog reset under a nested level. A design that lets the clear win loses a flag, and one that keeps stale pending state takes a trap after the reset vector.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int NUM_W = 7;
  localparam int LVL_W = 2;

  localparam logic [LVL_W-1:0] LVL_NONE  = 2'd0;
  localparam logic [LVL_W-1:0] LVL_FAULT = 2'd1;
  localparam logic [LVL_W-1:0] LVL_SYS   = 2'd2;
  localparam logic [LVL_W-1:0] LVL_RESET = 2'd3;

  localparam logic [NUM_W-1:0] NUM_RESET   = 7'h00;
  localparam logic [NUM_W-1:0] NUM_NMI     = 7'h02;
  localparam logic [NUM_W-1:0] NUM_STK_OVF = 7'h04;
  localparam logic [NUM_W-1:0] NUM_STK_UNF = 7'h06;
  localparam logic [NUM_W-1:0] NUM_FAULT   = 7'h0A;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic             take;
    logic [LVL_W-1:0] cls;
    logic [NUM_W-1:0] num;
    logic [2:0]       clrClassA;
    logic             clrFaults;
    logic             clrSw;
    logic             clrRst;
  } trap_ctl_t;

endpackage

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int FAULT_N = 5,
  parameter int ADDR_W  = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rstEvt,
  input  logic                 nmiReq,
  input  logic                 stkOvfReq,
  input  logic                 stkUnfReq,
  input  logic [FAULT_N-1:0]   faultReq,
  input  logic                 swTrapReq,
  input  logic [NUM_W-1:0]     swTrapNum,
  input  logic                 flagWe,
  input  logic [FAULT_N+2:0]   flagWdata,
  input  trap_ctl_t            ctl,
  output logic [FAULT_N+2:0]   flagRd,
  output logic [2:0]           pendA,
  output logic                 pendFault,
  output logic                 pendRst,
  output logic                 pendSw,
  output logic [NUM_W-1:0]     swNumHeld,
  output logic                 takeTrap,
  output logic [ADDR_W-1:0]    trapVector,
  output logic [NUM_W-1:0]     trapNum,
  output logic [LVL_W-1:0]     trapClass
);

  localparam int FLAG_W = FAULT_N + 3;
  localparam int PAD_W  = ADDR_W - NUM_W - 2;

  logic [FLAG_W-1:0]  flagReg;
  logic [FLAG_W-1:0]  evtVec;
  logic [FLAG_W-1:0]  keepMask;
  logic [2:0]         pendAReg;
  logic [FAULT_N-1:0] faultPendReg;
  logic               rstPendReg;
  logic               swPendReg;
  logic [NUM_W-1:0]   swNumReg;

  assign evtVec   = {faultReq, stkUnfReq, stkOvfReq, nmiReq};
  assign keepMask = flagWe ? flagWdata : {FLAG_W{1'b1}};

  // Sticky flags and pending requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg      <= '0;
      pendAReg     <= '0;
      faultPendReg <= '0;
      rstPendReg   <= 1'b1;
      swPendReg    <= 1'b0;
      swNumReg     <= '0;
    end else if (rstEvt) begin
      flagReg      <= '0;
      pendAReg     <= '0;
      faultPendReg <= '0;
      rstPendReg   <= 1'b1;
      swPendReg    <= 1'b0;
    end else begin
      flagReg      <= (flagReg & keepMask) | evtVec;
      pendAReg     <= (pendAReg & ~ctl.clrClassA) | evtVec[2:0];
      faultPendReg <= (faultPendReg & ~{FAULT_N{ctl.clrFaults}}) | faultReq;
      if (ctl.clrRst) rstPendReg <= 1'b0;
      if (swTrapReq) begin
        swPendReg <= 1'b1;
        swNumReg  <= swTrapNum;
      end else if (ctl.clrSw) begin
        swPendReg <= 1'b0;
      end
    end
  end

  // Registered take outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeTrap   <= 1'b0;
      trapNum    <= '0;
      trapClass  <= LVL_NONE;
      trapVector <= '0;
    end else begin
      takeTrap <= ctl.take;
      if (ctl.take) begin
        trapNum    <= ctl.num;
        trapClass  <= ctl.cls;
        trapVector <= {{PAD_W{1'b0}}, ctl.num, 2'b00};
      end
    end
  end

  assign flagRd    = flagReg;
  assign pendA     = pendAReg;
  assign pendFault = |faultPendReg;
  assign pendRst   = rstPendReg;
  assign pendSw    = swPendReg;
  assign swNumHeld = swNumReg;

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int NEST_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rstEvt,
  input  logic [2:0]       pendA,
  input  logic             pendFault,
  input  logic             pendRst,
  input  logic             pendSw,
  input  logic [NUM_W-1:0] swNum,
  input  logic             trapRet,
  output trap_ctl_t        ctl,
  output logic [LVL_W-1:0] activeLevel,
  output logic             intBlock
);

  logic [LVL_W-1:0] curLevel, curNext;
  logic [NEST_DEPTH-1:0][LVL_W-1:0] stk, stkNext;
  logic [LVL_W-1:0] hwCls;
  logic [NUM_W-1:0] hwNum;
  logic [2:0]       hwClrA;
  logic             hwFault, hwRst, hwGo;

  // Fixed-priority pick among pending hardware requests
  always_comb begin
    hwCls   = LVL_NONE;
    hwNum   = NUM_RESET;
    hwClrA  = 3'b000;
    hwFault = 1'b0;
    hwRst   = 1'b0;
    if (pendRst) begin
      hwCls = LVL_RESET;
      hwRst = 1'b1;
    end else if (pendA[0]) begin
      hwCls  = LVL_SYS;
      hwNum  = NUM_NMI;
      hwClrA = 3'b001;
    end else if (pendA[1]) begin
      hwCls  = LVL_SYS;
      hwNum  = NUM_STK_OVF;
      hwClrA = 3'b010;
    end else if (pendA[2]) begin
      hwCls  = LVL_SYS;
      hwNum  = NUM_STK_UNF;
      hwClrA = 3'b100;
    end else if (pendFault) begin
      hwCls   = LVL_FAULT;
      hwNum   = NUM_FAULT;
      hwFault = 1'b1;
    end
  end

  assign hwGo = hwRst | (hwCls > curLevel);

  always_comb begin
    ctl = '0;
    if (hwGo) begin
      ctl.take      = 1'b1;
      ctl.cls       = hwCls;
      ctl.num       = hwNum;
      ctl.clrClassA = hwClrA;
      ctl.clrFaults = hwFault;
      ctl.clrRst    = hwRst;
    end else if (pendSw) begin
      ctl.take  = 1'b1;
      ctl.cls   = LVL_NONE;
      ctl.num   = swNum;
      ctl.clrSw = 1'b1;
    end
  end

  // Nesting stack of in-service levels
  always_comb begin
    curNext = curLevel;
    stkNext = stk;
    if (rstEvt || (hwGo && hwRst)) begin
      curNext = LVL_NONE;
      stkNext = '0;
    end else if (hwGo) begin
      curNext    = hwCls;
      stkNext[0] = curLevel;
      for (int i = 1; i < NEST_DEPTH; i++) stkNext[i] = stk[i-1];
    end else if (trapRet) begin
      curNext = stk[0];
      for (int i = 0; i < NEST_DEPTH - 1; i++) stkNext[i] = stk[i+1];
      stkNext[NEST_DEPTH-1] = LVL_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel <= LVL_NONE;
      stk      <= '0;
    end else begin
      curLevel <= curNext;
      stk      <= stkNext;
    end
  end

  assign activeLevel = curLevel;
  assign intBlock    = (curLevel != LVL_NONE);

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_pkg::*;
#(
  parameter int FAULT_N    = 5,
  parameter int ADDR_W     = 24,
  parameter int NEST_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swRstReq,
  input  logic               wdtOvfReq,
  input  logic               nmiReq,
  input  logic               stkOvfReq,
  input  logic               stkUnfReq,
  input  logic [FAULT_N-1:0] faultReq,
  input  logic               swTrapReq,
  input  logic [6:0]         swTrapNum,
  input  logic               trapRet,
  input  logic               flagWe,
  input  logic [FAULT_N+2:0] flagWdata,
  output logic [FAULT_N+2:0] flagRd,
  output logic               takeTrap,
  output logic [ADDR_W-1:0]  trapVector,
  output logic [6:0]         trapNum,
  output logic [1:0]         trapClass,
  output logic               intBlock
);

  trap_ctl_t        ctl;
  logic [2:0]       pendA;
  logic             pendFault, pendRst, pendSw;
  logic [NUM_W-1:0] swNumHeld;
  logic [LVL_W-1:0] activeLevel;
  logic             rstEvt;

  assign rstEvt = swRstReq | wdtOvfReq;

  trap_dp #(.FAULT_N(FAULT_N), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .rstEvt(rstEvt),
    .nmiReq(nmiReq), .stkOvfReq(stkOvfReq), .stkUnfReq(stkUnfReq),
    .faultReq(faultReq), .swTrapReq(swTrapReq), .swTrapNum(swTrapNum),
    .flagWe(flagWe), .flagWdata(flagWdata), .ctl(ctl),
    .flagRd(flagRd), .pendA(pendA), .pendFault(pendFault),
    .pendRst(pendRst), .pendSw(pendSw), .swNumHeld(swNumHeld),
    .takeTrap(takeTrap), .trapVector(trapVector), .trapNum(trapNum),
    .trapClass(trapClass)
  );

  trap_ctrl #(.NEST_DEPTH(NEST_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rstEvt(rstEvt),
    .pendA(pendA), .pendFault(pendFault), .pendRst(pendRst),
    .pendSw(pendSw), .swNum(swNumHeld), .trapRet(trapRet),
    .ctl(ctl), .activeLevel(activeLevel), .intBlock(intBlock)
  );

endmodule

// File: rtl/trap_vector_unit_chk.sv
module trap_vector_unit_chk #(
  parameter int FAULT_N = 5,
  parameter int ADDR_W  = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               swRstReq,
  input logic               wdtOvfReq,
  input logic               flagWe,
  input logic [FAULT_N+2:0] flagRd,
  input logic               takeTrap,
  input logic [ADDR_W-1:0]  trapVector,
  input logic [6:0]         trapNum,
  input logic [1:0]         trapClass,
  input logic               intBlock,
  input logic [1:0]         activeLevel
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!flagWe && !swRstReq && !wdtOvfReq) |=> (($past(flagRd) & ~flagRd) == '0)); // R1

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (takeTrap && trapClass == 2'd3) |-> (trapVector == '0 && trapNum == 7'h00 && !intBlock)); // R2

  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (takeTrap && (trapClass == 2'd1 || trapClass == 2'd2))
      |-> ($past(activeLevel) < trapClass && activeLevel == trapClass)); // R6

  AST_VECTOR_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |-> (trapVector[1:0] == 2'b00 && (trapVector >> 2) == ADDR_W'(trapNum))); // R8

  AST_BLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    intBlock == (activeLevel != 2'd0)); // R9

  AST_HW_NUMBERS: assert property (@(posedge clk) disable iff (!rstN)
    (takeTrap && trapClass != 2'd0)
      |-> (trapNum == 7'h00 || trapNum == 7'h02 || trapNum == 7'h04 ||
           trapNum == 7'h06 || trapNum == 7'h0A)); // R10

endmodule

bind trap_vector_unit trap_vector_unit_chk #(.FAULT_N(FAULT_N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .swRstReq(swRstReq), .wdtOvfReq(wdtOvfReq),
  .flagWe(flagWe), .flagRd(flagRd), .takeTrap(takeTrap),
  .trapVector(trapVector), .trapNum(trapNum), .trapClass(trapClass),
  .intBlock(intBlock), .activeLevel(activeLevel)
);

// File: tb/trap_vector_unit_bench.sv
module trap_vector_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        swRstReq, wdtOvfReq, nmiReq, stkOvfReq, stkUnfReq;
  logic [4:0]  faultReq;
  logic        swTrapReq;
  logic [6:0]  swTrapNum;
  logic        trapRet, flagWe;
  logic [7:0]  flagWdata, flagRd;
  logic        takeTrap;
  logic [23:0] trapVector;
  logic [6:0]  trapNum;
  logic [1:0]  trapClass;
  logic        intBlock;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_vector_unit u_trap_vector_unit (
    .clk(clk), .rstN(rstN), .swRstReq(swRstReq), .wdtOvfReq(wdtOvfReq),
    .nmiReq(nmiReq), .stkOvfReq(stkOvfReq), .stkUnfReq(stkUnfReq),
    .faultReq(faultReq), .swTrapReq(swTrapReq), .swTrapNum(swTrapNum),
    .trapRet(trapRet), .flagWe(flagWe), .flagWdata(flagWdata),
    .flagRd(flagRd), .takeTrap(takeTrap), .trapVector(trapVector),
    .trapNum(trapNum), .trapClass(trapClass), .intBlock(intBlock)
  );

  typedef struct packed {
    logic       nmi;
    logic       ovf;
    logic       unf;
    logic [4:0] flt;
    logic       ret;
    logic       take;
    logic [6:0] num;
    logic [1:0] cls;
    logic       blk;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 5'b00001, 1'b0, 1'b1, 7'h0A, 2'd1, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'b10000, 1'b0, 1'b0, 7'h00, 2'd0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1, 7'h02, 2'd2, 1'b1},
    '{1'b0, 1'b1, 1'b1, 5'b00000, 1'b0, 1'b0, 7'h00, 2'd0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b1, 7'h04, 2'd2, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b1, 7'h06, 2'd2, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0, 7'h00, 2'd0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b1, 7'h0A, 2'd1, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0, 7'h00, 2'd0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0, 7'h00, 2'd0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expectTake(input string req, input logic [6:0] num,
                            input logic [1:0] cls, input logic blk);
    check(takeTrap == 1'b1, req, "take strobe", 32'(takeTrap), 32'd1);
    check(trapNum == num, req, "trap number", 32'(trapNum), 32'(num));
    check(trapClass == cls, req, "trap class", 32'(trapClass), 32'(cls));
    check(trapVector == 24'({num, 2'b00}), req, "vector", 32'(trapVector), 32'({num, 2'b00}));
    check(intBlock == blk, req, "block", 32'(intBlock), 32'(blk));
  endtask

  task automatic expectIdle(input string req, input logic blk);
    check(takeTrap == 1'b0, req, "no take", 32'(takeTrap), 32'd0);
    check(intBlock == blk, req, "block", 32'(intBlock), 32'(blk));
  endtask

  task automatic clearInputs();
    swRstReq = 1'b0; wdtOvfReq = 1'b0; nmiReq = 1'b0; stkOvfReq = 1'b0;
    stkUnfReq = 1'b0; faultReq = '0; swTrapReq = 1'b0; trapRet = 1'b0;
    flagWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    clearInputs();
    swTrapNum = '0;
    flagWdata = '0;
    repeat (3) @(negedge clk);

    // R2: state held in reset
    check(takeTrap == 1'b0, "R2", "take in reset", 32'(takeTrap), 32'd0);
    check(flagRd == 8'h00, "R2", "flags in reset", 32'(flagRd), 32'd0);
    check(intBlock == 1'b0, "R2", "block in reset", 32'(intBlock), 32'd0);

    // R2: reset trap one edge after release
    rstN = 1'b1;
    @(negedge clk);
    expectTake("R2", 7'h00, 2'd3, 1'b0);
    @(negedge clk);
    expectIdle("R10 single-cycle strobe", 1'b0);

    // R3 R4 R5 R6 R7 R9: nesting table
    for (int i = 0; i < NVEC; i++) begin
      nmiReq = TBL[i].nmi; stkOvfReq = TBL[i].ovf; stkUnfReq = TBL[i].unf;
      faultReq = TBL[i].flt; trapRet = TBL[i].ret;
      @(negedge clk);
      clearInputs();
      @(negedge clk);
      if (TBL[i].take) expectTake("R3 R4 R5 R6 R7 table", TBL[i].num, TBL[i].cls, TBL[i].blk);
      else expectIdle("R6 R7 R9 table", TBL[i].blk);
    end

    // R1: flags accumulated by the table
    check(flagRd == 8'h8F, "R1", "flags after table", 32'(flagRd), 32'h8F);

    // R1: writing zeros clears, writing ones keeps
    flagWe = 1'b1; flagWdata = 8'h7F;
    @(negedge clk); clearInputs();
    check(flagRd == 8'h0F, "R1", "clear bit 7", 32'(flagRd), 32'h0F);
    flagWe = 1'b1; flagWdata = 8'hFF;
    @(negedge clk); clearInputs();
    check(flagRd == 8'h0F, "R1", "write ones", 32'(flagRd), 32'h0F);

    // R1: event beats a clearing write in the same cycle
    flagWe = 1'b1; flagWdata = 8'hF0; nmiReq = 1'b1;
    @(negedge clk); clearInputs();
    check(flagRd == 8'h01, "R1", "event wins", 32'(flagRd), 32'h01);
    @(negedge clk);
    expectTake("R3 nmi", 7'h02, 2'd2, 1'b1);
    trapRet = 1'b1;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectIdle("R7 back to idle", 1'b0);

    // R8: software trap at top number
    swTrapReq = 1'b1; swTrapNum = 7'h7F;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectTake("R8 top number", 7'h7F, 2'd0, 1'b0);

    // R5 R8: hardware and software together, hardware first
    nmiReq = 1'b1; swTrapReq = 1'b1; swTrapNum = 7'h0B;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectTake("R5 hw before sw", 7'h02, 2'd2, 1'b1);
    @(negedge clk);
    expectTake("R8 sw after hw", 7'h0B, 2'd0, 1'b1);

    // R6: same class waits
    stkOvfReq = 1'b1;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectIdle("R6 equal class waits", 1'b1);

    // R8: software trap still taken under an active level
    swTrapReq = 1'b1; swTrapNum = 7'h05;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectTake("R8 under level", 7'h05, 2'd0, 1'b1);

    // R1 R6: several faults at once, blocked by level
    faultReq = 5'b10101;
    @(negedge clk); clearInputs();
    check(flagRd == 8'hAB, "R1", "multi fault flags", 32'(flagRd), 32'hAB);
    @(negedge clk);
    expectIdle("R6 lower class waits", 1'b1);

    // R2: watchdog reset clears everything, then vector 0
    wdtOvfReq = 1'b1;
    @(negedge clk); clearInputs();
    check(flagRd == 8'h00, "R2", "flags cleared", 32'(flagRd), 32'h00);
    expectIdle("R2 stack cleared", 1'b0);
    @(negedge clk);
    expectTake("R2 watchdog", 7'h00, 2'd3, 1'b0);
    trapRet = 1'b1;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectIdle("R2 pending cleared", 1'b0);

    // R5: cross-class request in one cycle at level 0
    nmiReq = 1'b1; faultReq = 5'b00010;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectTake("R5 class order", 7'h02, 2'd2, 1'b1);
    trapRet = 1'b1;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectTake("R4 R7 fault after return", 7'h0A, 2'd1, 1'b1);

    // R2: software reset from nested level
    swRstReq = 1'b1;
    @(negedge clk); clearInputs();
    @(negedge clk);
    expectTake("R2 software reset", 7'h00, 2'd3, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule